// File: doc/BRIEF.md
# Load/Store Age-Ordered Issue Arbiter

This block chooses, every cycle, which memory operation of an out-of-order core may use the data memory port. Four load/store reservation slots feed it. Besides them it keeps an age buffer that holds pointers to the occupied slots, never the operations, listed from oldest (position 0) to youngest. Issue adds an entry by naming a slot and saying whether it holds a load or a store. The slots report a per-slot ready flag once address and operands are known. The reorder buffer raises a commit-permission signal when the store at its commit point may be written.

A store can leave only from the head of the buffer, and only while commit permission is high. Until that store leaves, it fences off every younger load. Loads older than the first buffered store may leave out of order, and the oldest ready one always wins. When an entry leaves from the middle, every younger entry moves one position toward the head. An allocation made in the same cycle lands in the first free position after that move.

Occupancy is tracked by a three-state machine. `OCC_EMPTY` means no entries. `OCC_OPEN` means one to three entries. `OCC_FULL` means four entries. Its transitions are FILL (EMPTY to OPEN on an allocation), TOP_OFF (OPEN to FULL when the fourth entry arrives), DRAIN_ONE (FULL to OPEN on a removal), and DRAIN_LAST (OPEN to EMPTY when the last entry leaves). Any other combination holds the current state. Grants are combinational from the current buffer and inputs. A grant in a cycle removes that entry at the next rising edge.

Top module: `lsq_age_arbiter`

## Requirements
- R1: After reset the buffer is empty: `mem_en` is 0, `grant` is all zeros and `full` is 0.
- R2: When the entry at position 0 is a store and `st_commit_ok` is 1, that store's slot is granted, whatever the ready loads do.
- R3: A store is never granted unless it is at position 0 with `st_commit_ok` high. A store at the head with `st_commit_ok` low is not granted.
- R4: A load is never granted while any store sits at an older position of the age buffer.
- R5: Among eligible loads (ready, with no older store), the one at the oldest position is granted.
- R6: At most one slot is granted per cycle. `grant` is one-hot, bit i meaning slot i. `grant_slot` is the binary index of that slot. `mem_en` is 1 exactly when a grant is given.
- R7: When no entry is eligible, `mem_en` is 0 and `grant` is all zeros.
- R8: A removal from the middle closes the gap while keeping the relative age order of the remaining entries.
- R9: An allocation and a grant in the same cycle both take effect. The new entry becomes the youngest, placed after compaction.
- R10: `full` is 1 while four entries are held. An allocation presented while `full` is 1 is ignored.
- R11: A ready load that is blocked behind a store keeps its place. It is granted as soon as it becomes the oldest eligible entry.
- R12: An allocation is accepted when `alloc_valid` is 1 and `full` is 0. `alloc_is_store` 1 marks a store and 0 marks a load. `alloc_slot` is the slot index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Issue adds an entry this cycle |
| alloc_slot | input | 2 | Reservation slot index of the new entry |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| slot_ready | input | 4 | Per-slot ready flag, bit i for slot i |
| st_commit_ok | input | 1 | Reorder buffer permits the head store to write |
| grant | output | 4 | One-hot grant, bit i for slot i |
| mem_en | output | 1 | Memory port enable |
| grant_slot | output | 2 | Binary index of the granted slot |
| full | output | 1 | Four entries held; issue must stall |

## Verification
On every cycle, the embedded assertions check the following:
- the grant is one-hot and agrees with the slot index;
- a granted store is at the head with permission, and no granted load has a store at the head ahead of it;
- the entry count never exceeds four, and it does not move when an allocation arrives while full with nothing leaving;
- an empty buffer never enables memory.

Some behaviours only the bench's scenarios can show, because they span several cycles of buffer history:
- that compaction keeps the age order, seen through the order of later grants;
- that the oldest eligible load, rather than just any load, is chosen;
- that a blocked load eventually leaves once its fencing store commits;
- that an allocation in a removal cycle lands as the youngest entry.

// File: rtl/lsq_arb_pkg.sv
package lsq_arb_pkg;

    localparam int LSQ_SLOTS = 4;
    localparam int LSQ_IDX_W = $clog2(LSQ_SLOTS);

    // One age-buffer entry: a pointer to a reservation slot plus its kind.
    typedef struct packed {
        logic                 vld;
        logic                 is_st;
        logic [LSQ_IDX_W-1:0] slot;
    } age_ent_t;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_OPEN  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;

endpackage

// File: rtl/lsq_age_buffer.sv
module lsq_age_buffer
    import lsq_arb_pkg::*;
#(
    parameter int DEPTH = LSQ_SLOTS,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_en,
    input  logic [IDX_W-1:0]       alloc_slot,
    input  logic                   alloc_st,
    input  logic                   rm_en,
    input  logic [IDX_W-1:0]       rm_pos,
    output age_ent_t [DEPTH-1:0]   ents,
    output logic [CNT_W-1:0]       count
);

    age_ent_t [DEPTH-1:0] shifted;
    age_ent_t [DEPTH-1:0] ents_nxt;
    logic [CNT_W-1:0]     cnt_after;
    logic [CNT_W-1:0]     cnt_nxt;

    // Compaction: positions at or behind the removed one take their younger neighbour.
    generate
        for (genvar p = 0; p < DEPTH; p++) begin : g_shift
            if (p == DEPTH - 1) begin : g_last
                always_comb begin
                    if (rm_en && (IDX_W'(p) >= rm_pos))
                        shifted[p] = '0;
                    else
                        shifted[p] = ents[p];
                end
            end else begin : g_mid
                always_comb begin
                    if (rm_en && (IDX_W'(p) >= rm_pos))
                        shifted[p] = ents[p+1];
                    else
                        shifted[p] = ents[p];
                end
            end
        end
    endgenerate

    assign cnt_after = count - CNT_W'(rm_en);
    assign cnt_nxt   = cnt_after + CNT_W'(alloc_en);

    // Append after compaction: the new entry takes the first free position.
    always_comb begin
        ents_nxt = shifted;
        for (int p = 0; p < DEPTH; p++) begin
            if (alloc_en && (CNT_W'(p) == cnt_after)) begin
                ents_nxt[p].vld   = 1'b1;
                ents_nxt[p].is_st = alloc_st;
                ents_nxt[p].slot  = alloc_slot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ents  <= '0;
            count <= '0;
        end else begin
            ents  <= ents_nxt;
            count <= cnt_nxt;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)) else $error("count above depth"); // R10

    AST_REMOVE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rm_en |-> ents[rm_pos].vld) else $error("removal of empty position"); // R8

    AST_REMOVE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_en && !alloc_en) |=> (count == $past(count) - CNT_W'(1))) else $error("removal lost"); // R9

    AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_en && alloc_en) |=> (count == $past(count))) else $error("alloc plus removal miscounted"); // R9

endmodule

// File: rtl/lsq_pick.sv
module lsq_pick
    import lsq_arb_pkg::*;
#(
    parameter int DEPTH = LSQ_SLOTS,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  age_ent_t [DEPTH-1:0] ents,
    input  logic [DEPTH-1:0]     slot_ready,
    input  logic                 commit_ok,
    output logic                 pick_vld,
    output logic [IDX_W-1:0]     pick_pos,
    output logic [IDX_W-1:0]     pick_slot
);

    logic fenced;

    // Step one: head store with permission. Step two: oldest ready unfenced load.
    always_comb begin
        pick_vld  = 1'b0;
        pick_pos  = '0;
        pick_slot = '0;
        fenced    = 1'b0;
        if (ents[0].vld && ents[0].is_st && commit_ok) begin
            pick_vld  = 1'b1;
            pick_pos  = '0;
            pick_slot = ents[0].slot;
        end else begin
            for (int p = 0; p < DEPTH; p++) begin
                if (ents[p].vld && !fenced && !pick_vld && !ents[p].is_st
                    && slot_ready[ents[p].slot]) begin
                    pick_vld  = 1'b1;
                    pick_pos  = IDX_W'(p);
                    pick_slot = ents[p].slot;
                end
                if (ents[p].vld && ents[p].is_st)
                    fenced = 1'b1;
            end
        end
    end

    AST_STORE_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_vld && ents[pick_pos].is_st) |-> (pick_pos == '0 && commit_ok))
        else $error("store granted away from head"); // R3

    AST_HEAD_STORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ents[0].vld && ents[0].is_st && commit_ok) |-> (pick_vld && pick_pos == '0))
        else $error("permitted head store not granted"); // R2

    AST_LOAD_UNFENCED: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_vld && !ents[pick_pos].is_st && pick_pos != '0) |-> !ents[0].is_st)
        else $error("load passed head store"); // R4

    AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_vld && !ents[pick_pos].is_st) |-> slot_ready[pick_slot])
        else $error("unready load granted"); // R5

endmodule

// File: rtl/lsq_age_arbiter.sv
module lsq_age_arbiter
    import lsq_arb_pkg::*;
#(
    parameter int NUM_SLOTS = LSQ_SLOTS,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_valid,
    input  logic [IDX_W-1:0]     alloc_slot,
    input  logic                 alloc_is_store,
    input  logic [NUM_SLOTS-1:0] slot_ready,
    input  logic                 st_commit_ok,
    output logic [NUM_SLOTS-1:0] grant,
    output logic                 mem_en,
    output logic [IDX_W-1:0]     grant_slot,
    output logic                 full
);

    occ_state_t               state, state_nxt;
    age_ent_t [NUM_SLOTS-1:0] ents;
    logic [CNT_W-1:0]         count;
    logic [CNT_W-1:0]         occ_nxt;
    logic                     alloc_acc;
    logic                     pick_vld;
    logic [IDX_W-1:0]         pick_pos;
    logic [IDX_W-1:0]         pick_slot;
    logic                     rm_en;

    assign alloc_acc = alloc_valid && (state != OCC_FULL);
    assign rm_en     = mem_en;

    lsq_age_buffer #(.DEPTH(NUM_SLOTS)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_acc),
        .alloc_slot (alloc_slot),
        .alloc_st   (alloc_is_store),
        .rm_en      (rm_en),
        .rm_pos     (pick_pos),
        .ents       (ents),
        .count      (count)
    );

    lsq_pick #(.DEPTH(NUM_SLOTS)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .ents       (ents),
        .slot_ready (slot_ready),
        .commit_ok  (st_commit_ok),
        .pick_vld   (pick_vld),
        .pick_pos   (pick_pos),
        .pick_slot  (pick_slot)
    );

    assign occ_nxt = count - CNT_W'(rm_en) + CNT_W'(alloc_acc);

    // Next-state logic: FILL, TOP_OFF, DRAIN_ONE, DRAIN_LAST.
    always_comb begin
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: if (alloc_acc) state_nxt = OCC_OPEN;                        // FILL
            OCC_OPEN: begin
                if (occ_nxt == CNT_W'(NUM_SLOTS)) state_nxt = OCC_FULL;           // TOP_OFF
                else if (occ_nxt == '0)           state_nxt = OCC_EMPTY;          // DRAIN_LAST
            end
            OCC_FULL: if (rm_en) state_nxt = OCC_OPEN;                             // DRAIN_ONE
            default:  state_nxt = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OCC_EMPTY;
        else        state <= state_nxt;
    end

    // Output logic.
    always_comb begin
        grant      = '0;
        mem_en     = 1'b0;
        grant_slot = '0;
        full       = 1'b0;
        unique case (state)
            OCC_EMPTY: ;
            OCC_OPEN, OCC_FULL: begin
                full       = (state == OCC_FULL);
                mem_en     = pick_vld;
                grant_slot = pick_slot;
                if (pick_vld) grant = NUM_SLOTS'(1) << pick_slot;
            end
            default: ;
        endcase
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)) else $error("multiple grants"); // R6

    AST_EN_MATCHES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> grant[grant_slot]) else $error("enable without matching grant"); // R6

    AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !mem_en) else $error("enable with empty buffer"); // R7

    AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (count == CNT_W'(NUM_SLOTS))) else $error("full flag wrong"); // R10

    AST_FULL_IGNORES_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_valid && !mem_en) |=> full) else $error("alloc while full altered state"); // R10

endmodule

// File: tb/lsq_age_arbiter_tb.sv
module lsq_age_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_valid = 1'b0;
    logic [1:0] alloc_slot = '0;
    logic       alloc_is_store = 1'b0;
    logic [3:0] slot_ready = '0;
    logic       st_commit_ok = 1'b0;
    logic [3:0] grant;
    logic       mem_en;
    logic [1:0] grant_slot;
    logic       full;

    int checks = 0;
    int errors = 0;

    // Reference model: age order of slot pointers, position 0 oldest.
    int m_slot [4];
    bit m_st   [4];
    int m_cnt = 0;

    always #4 clk = ~clk;

    lsq_age_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_slot(alloc_slot),
        .alloc_is_store(alloc_is_store), .slot_ready(slot_ready), .st_commit_ok(st_commit_ok),
        .grant(grant), .mem_en(mem_en), .grant_slot(grant_slot), .full(full)
    );

    function automatic int exp_pos(input logic [3:0] rdy, input logic ok);
        if (m_cnt > 0 && m_st[0] && ok) return 0;
        for (int i = 0; i < m_cnt; i++) begin
            if (m_st[i]) return -1;
            if (rdy[m_slot[i]]) return i;
        end
        return -1;
    endfunction

    function automatic bit slot_used(input int s);
        for (int i = 0; i < m_cnt; i++) if (m_slot[i] == s) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(input bit av, input int sl, input bit st, input logic [3:0] rdy,
                        input logic ok, input string tag);
        int p;
        logic [3:0] eg;
        logic ee, ef;
        logic [1:0] es;
        alloc_valid = av; alloc_slot = 2'(sl); alloc_is_store = st;
        slot_ready = rdy; st_commit_ok = ok;
        #2;
        p  = exp_pos(rdy, ok);
        ee = (p >= 0);
        es = ee ? 2'(m_slot[p]) : 2'd0;
        eg = ee ? (4'd1 << es) : 4'd0;
        ef = (m_cnt == 4);
        checks++;
        if (grant !== eg || mem_en !== ee || (ee && grant_slot !== es) || full !== ef) begin
            errors++;
            $display("FAIL %s: grant=%b en=%b slot=%0d full=%b expected grant=%b en=%b slot=%0d full=%b",
                     tag, grant, mem_en, grant_slot, full, eg, ee, es, ef);
        end
        @(posedge clk);
        if (p >= 0) begin
            for (int i = p; i < m_cnt - 1; i++) begin
                m_slot[i] = m_slot[i+1]; m_st[i] = m_st[i+1];
            end
            m_cnt--;
        end
        if (av && !ef) begin
            m_slot[m_cnt] = sl; m_st[m_cnt] = st; m_cnt++;
        end
        @(negedge clk);
    endtask

    task automatic drain;
        while (m_cnt > 0) step(1'b0, 0, 1'b0, 4'hF, 1'b1, "R2 drain");
    endtask

    initial begin
        #1_600_000;
        errors++; checks++;
        $display("FAIL watchdog: expired expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (2) @(negedge clk);
        // R1: reset state
        checks++;
        if (grant !== 4'd0 || mem_en !== 1'b0 || full !== 1'b0) begin
            errors++;
            $display("FAIL R1: grant=%b en=%b full=%b expected 0000 0 0", grant, mem_en, full);
        end
        rst_n = 1'b1;
        @(negedge clk);
        step(1'b0, 0, 1'b0, 4'hF, 1'b1, "R7 empty idle");

        // R5/R4/R2/R11: load(2) older than store(0), younger load(1)
        step(1'b1, 2, 1'b0, 4'h0, 1'b0, "R12 alloc load");
        step(1'b1, 0, 1'b1, 4'h0, 1'b0, "R12 alloc store");
        step(1'b1, 1, 1'b0, 4'h0, 1'b0, "R7 nothing ready");
        step(1'b0, 0, 1'b0, 4'hF, 1'b0, "R5 older load leaves");
        step(1'b0, 0, 1'b0, 4'hF, 1'b0, "R3 head store waits; R4 younger load fenced");
        step(1'b0, 0, 1'b0, 4'hF, 1'b0, "R11 blocked load held");
        step(1'b0, 0, 1'b0, 4'hF, 1'b1, "R2 head store granted");
        step(1'b0, 0, 1'b0, 4'hF, 1'b0, "R11 released load granted");
        step(1'b0, 0, 1'b0, 4'hF, 1'b0, "R7 empty after drain");

        // R8: middle removal keeps order
        step(1'b1, 0, 1'b0, 4'h0, 1'b0, "R12 alloc");
        step(1'b1, 1, 1'b0, 4'h0, 1'b0, "R12 alloc");
        step(1'b1, 2, 1'b0, 4'h0, 1'b0, "R12 alloc");
        step(1'b0, 0, 1'b0, 4'b0010, 1'b0, "R8 middle load leaves");
        step(1'b1, 3, 1'b0, 4'b1101, 1'b0, "R9 alloc with grant");
        step(1'b0, 0, 1'b0, 4'b1100, 1'b0, "R8 order kept after compaction");
        step(1'b0, 0, 1'b0, 4'b1000, 1'b0, "R9 new entry youngest");

        // R10: fill to four, alloc while full ignored
        step(1'b1, 0, 1'b1, 4'h0, 1'b0, "R12 alloc store");
        step(1'b1, 1, 1'b0, 4'h0, 1'b0, "R12 alloc");
        step(1'b1, 2, 1'b1, 4'h0, 1'b0, "R12 alloc store");
        step(1'b1, 3, 1'b0, 4'h0, 1'b0, "R10 becomes full");
        step(1'b1, 3, 1'b1, 4'hF, 1'b0, "R10 alloc while full ignored");
        step(1'b0, 0, 1'b0, 4'hF, 1'b1, "R10 still full then store leaves");
        step(1'b0, 0, 1'b0, 4'hF, 1'b0, "R5 load before second store");
        step(1'b0, 0, 1'b0, 4'hF, 1'b0, "R4 load fenced by second store");
        drain();

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit av, st;
            int sl;
            av = ($urandom % 3) != 0;
            st = ($urandom % 3) == 0;
            sl = $urandom % 4;
            if (m_cnt < 4) begin
                for (int k = 0; k < 4 && slot_used(sl); k++) sl = (sl + 1) % 4;
            end
            step(av, sl, st, 4'($urandom), 1'(($urandom % 4) == 0), "R6 random");
        end
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule